// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor Core

This block is a small processor core whose entire instruction set is one operation. Each instruction takes a minuend and a subtrahend, writes their difference to a destination register, and then jumps by a signed relative offset if that difference is negative. If the difference is not negative, execution moves on to the next instruction. Either operand can name a register or carry a small signed constant. Register zero always reads as zero, so a program can use it as a destination when it only wants the comparison.

Programs live in a 16-word instruction store. The store is loaded through a write port while the core is stopped. Data lives in a 32-entry, 32-bit register file. A debug port reads any register at any time and writes registers while the core is stopped. Software controls the core with a run enable and a soft clear. It observes a sticky finished flag and a count of executed instructions. The core retires one instruction per clock and finishes when the program counter steps outside the instruction store.

Top module: `sbn_core`

## Requirements
- R1: Register 0 reads as zero through the debug port at all times. Writes to it from an instruction or from the debug port are discarded.
- R2: Instruction word layout: bits 7..0 hold the subtrahend field, bits 15..8 the minuend field and bits 23..16 the destination field. Bit 24 set makes the subtrahend an immediate, and bit 25 set makes the minuend an immediate. The core writes minuend minus subtrahend, in 32-bit two's complement. An immediate is the 8-bit field sign-extended. A register field uses only its low 5 bits.
- R3: When bit 31 of the difference is 1, the next PC is the PC plus the sign-extended 4-bit offset in bits 31..28. Otherwise the next PC is the PC plus 1. This holds even when the destination is register 0.
- R4: While run_en is 1, soft_rst is 0 and done is 0, the core executes exactly one instruction per clock, and insn_count rises by one per executed instruction.
- R5: When the next PC falls outside 0..15, done goes to 1 after that instruction. The core then executes nothing more, and done stays 1 until soft_rst or rst_n.
- R6: rst_n low (synchronous) clears the register file, the instruction store, the PC, done and insn_count. A soft_rst pulse clears the PC, done and insn_count but keeps the register and instruction contents.
- R7: dbg_rdata shows the register selected by dbg_addr in the same cycle, with no clock edge needed.
- R8: A debug write (dbg_we) lands only in a cycle where no instruction executes. In an executing cycle it is dropped, and the instruction's own write stands.
- R9: An instruction store write (imem_we) lands only in a cycle where no instruction executes. Otherwise it is dropped.
- R10: Lowering run_en pauses the core with the PC, registers, done and count held. Raising it again resumes at the same PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Execute while high |
| soft_rst | input | 1 | Synchronous clear of PC, done and count |
| done | output | 1 | Sticky: PC left the instruction store |
| insn_count | output | 32 | Instructions executed since the last clear |
| imem_we | input | 1 | Instruction store write strobe |
| imem_waddr | input | 4 | Instruction store write index |
| imem_wdata | input | 32 | Instruction word to store |
| dbg_addr | input | 5 | Register selected for debug read and write |
| dbg_we | input | 1 | Debug register write strobe |
| dbg_wdata | input | 32 | Debug register write data |
| dbg_rdata | output | 32 | Selected register contents, combinational |

## Verification
An executing instruction and a debug or instruction-store write can arrive in the same cycle, because the external strobes are asynchronous to the program. The bench provokes this collision by driving random dbg_we and imem_we traffic, with random addresses and data, during every cycle the reference model says the core is executing. Writes arriving after the core has finished are taken as legal. The collision is judged by reading back all 32 registers, the count and the done flag after each run and comparing them with a model that discards every write made in an executing cycle. Any leak of a dropped write shows up as a register or program-flow mismatch.

// File: rtl/sbn_pkg.sv
// Package: shared instruction layout for the subtract-and-branch core.
// Assumes a fixed 32-bit instruction word; field positions are behaviour.
package sbn_pkg;

    localparam int INSN_W  = 32;
    localparam int FIELD_W = 8;
    localparam int OFF_W   = 4;

    // Decoded view of one instruction word.
    typedef struct packed {
        logic [OFF_W-1:0]   off;     // signed relative branch distance
        logic               m_imm;   // minuend field is a constant
        logic               s_imm;   // subtrahend field is a constant
        logic [FIELD_W-1:0] dst_f;   // destination register field
        logic [FIELD_W-1:0] min_f;   // minuend field
        logic [FIELD_W-1:0] sub_f;   // subtrahend field
    } insn_t;

    // Split an instruction word into its fields.
    function automatic insn_t decode(input logic [INSN_W-1:0] w);
        insn_t d;
        d.off   = w[31:28];
        d.m_imm = w[25];
        d.s_imm = w[24];
        d.dst_f = w[23:16];
        d.min_f = w[15:8];
        d.sub_f = w[7:0];
        return d;
    endfunction

endpackage

// File: rtl/sbn_imem.sv
// Module: sbn_imem
// Instruction store with one synchronous write port and one combinational
// read port. Cleared by the synchronous active-low reset.
// Assumes the caller gates writes so they never coincide with execution.
module sbn_imem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    // Store update: clear on reset, else write the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Fetch path: combinational read at the current PC.
    always_comb rdata = mem_q[raddr];

endmodule

// File: rtl/sbn_regfile.sv
// Module: sbn_regfile
// Register file with one write port and three combinational read ports
// (two operands, one debug). Entry 0 has no storage and reads zero.
// Assumes a single writer per cycle, chosen by the caller.
module sbn_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  ra_m,
    output logic [XLEN-1:0] rd_m,
    input  logic [RAW-1:0]  ra_s,
    output logic [XLEN-1:0] rd_s,
    input  logic [RAW-1:0]  ra_d,
    output logic [XLEN-1:0] rd_d
);

    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        if (g == 0) begin : g_zero
            // Entry 0: hardwired zero, never written.
            always_comb regs[g] = '0;
        end else begin : g_flop
            logic [XLEN-1:0] val_q;
            // Entry update: clear on reset, load when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (we && (waddr == RAW'(g))) begin
                    val_q <= wdata;
                end
            end
            always_comb regs[g] = val_q;
        end
    end

    // Read ports: plain array selects.
    always_comb begin
        rd_m = regs[ra_m];
        rd_s = regs[ra_s];
        rd_d = regs[ra_d];
    end

endmodule

// File: rtl/sbn_exec.sv
// Module: sbn_exec
// Combinational execute stage: operand selection, subtraction, branch
// decision and next-PC computation with out-of-range detection.
// Assumes DEPTH is a power of two and register fields fit in 8 bits.
module sbn_exec
    import sbn_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int DEPTH = 16,
    localparam int RAW  = $clog2(NREG),
    localparam int AW   = $clog2(DEPTH),
    localparam int NW   = ((AW > OFF_W) ? AW : OFF_W) + 2
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [AW-1:0]     pc,
    output logic [RAW-1:0]    ra_m,
    output logic [RAW-1:0]    ra_s,
    input  logic [XLEN-1:0]   rd_m,
    input  logic [XLEN-1:0]   rd_s,
    output logic [RAW-1:0]    dst,
    output logic [XLEN-1:0]   diff,
    output logic [AW-1:0]     next_pc,
    output logic              leave
);

    insn_t                  d;
    logic [XLEN-1:0]        op_m;
    logic [XLEN-1:0]        op_s;
    logic signed [NW-1:0]   pc_s;
    logic signed [NW-1:0]   off_s;
    logic signed [NW-1:0]   nxt_s;
    logic                   unused_bits;

    // Field split and register-number selection.
    always_comb begin
        d    = decode(insn);
        ra_m = d.min_f[RAW-1:0];
        ra_s = d.sub_f[RAW-1:0];
        dst  = d.dst_f[RAW-1:0];
    end

    // Operand select: sign-extended constant or register contents.
    always_comb begin
        op_m = d.m_imm ? {{(XLEN-FIELD_W){d.min_f[FIELD_W-1]}}, d.min_f} : rd_m;
        op_s = d.s_imm ? {{(XLEN-FIELD_W){d.sub_f[FIELD_W-1]}}, d.sub_f} : rd_s;
        diff = op_m - op_s;
    end

    // Next PC: relative jump when the difference is negative, else step.
    always_comb begin
        pc_s    = $signed({{(NW-AW){1'b0}}, pc});
        off_s   = $signed({{(NW-OFF_W){d.off[OFF_W-1]}}, d.off});
        nxt_s   = diff[XLEN-1] ? (pc_s + off_s) : (pc_s + NW'(1));
        next_pc = nxt_s[AW-1:0];
        leave   = nxt_s[NW-1] | (|nxt_s[NW-2:AW]);
    end

    assign unused_bits = ^{insn[27:26], d.dst_f, d.min_f, d.sub_f};

endmodule

// File: rtl/sbn_core.sv
// Module: sbn_core (top)
// Non-pipelined single-instruction processor: every clock while running it
// fetches, executes and retires one subtract-and-branch instruction.
// Assumes the store and registers are loaded while the core is stopped;
// writes arriving during an executing cycle are dropped.
module sbn_core #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int DEPTH = 16,
    parameter int CNTW  = 32,
    localparam int RAW  = $clog2(NREG),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_en,
    input  logic                      soft_rst,
    output logic                      done,
    output logic [CNTW-1:0]           insn_count,
    input  logic                      imem_we,
    input  logic [AW-1:0]             imem_waddr,
    input  logic [sbn_pkg::INSN_W-1:0] imem_wdata,
    input  logic [RAW-1:0]            dbg_addr,
    input  logic                      dbg_we,
    input  logic [XLEN-1:0]           dbg_wdata,
    output logic [XLEN-1:0]           dbg_rdata
);

    logic [AW-1:0]              pc_q;
    logic                       done_q;
    logic [CNTW-1:0]            cnt_q;
    logic                       exec;
    logic [sbn_pkg::INSN_W-1:0] insn;
    logic [RAW-1:0]             ra_m, ra_s, dst;
    logic [XLEN-1:0]            rd_m, rd_s, diff;
    logic [AW-1:0]              next_pc;
    logic                       leave;
    logic                       rf_we;
    logic [RAW-1:0]             rf_waddr;
    logic [XLEN-1:0]            rf_wdata;

    // Execute qualifier: one instruction retires in each such cycle.
    assign exec = run_en & ~soft_rst & ~done_q;

    // Register write port arbitration: execution owns it when active.
    always_comb begin
        if (exec) begin
            rf_we    = 1'b1;
            rf_waddr = dst;
            rf_wdata = diff;
        end else begin
            rf_we    = dbg_we;
            rf_waddr = dbg_addr;
            rf_wdata = dbg_wdata;
        end
    end

    sbn_imem #(
        .DEPTH (DEPTH),
        .WIDTH (sbn_pkg::INSN_W)
    ) u_imem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (imem_we & ~exec),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (pc_q),
        .rdata (insn)
    );

    sbn_regfile #(
        .XLEN (XLEN),
        .NREG (NREG)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra_m  (ra_m),
        .rd_m  (rd_m),
        .ra_s  (ra_s),
        .rd_s  (rd_s),
        .ra_d  (dbg_addr),
        .rd_d  (dbg_rdata)
    );

    sbn_exec #(
        .XLEN  (XLEN),
        .NREG  (NREG),
        .DEPTH (DEPTH)
    ) u_exec (
        .insn    (insn),
        .pc      (pc_q),
        .ra_m    (ra_m),
        .ra_s    (ra_s),
        .rd_m    (rd_m),
        .rd_s    (rd_s),
        .dst     (dst),
        .diff    (diff),
        .next_pc (next_pc),
        .leave   (leave)
    );

    // Sequencing state: PC, sticky finish flag and retired count.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pc_q   <= '0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else if (exec) begin
            pc_q   <= next_pc;
            cnt_q  <= cnt_q + CNTW'(1);
            if (leave) done_q <= 1'b1;
        end
    end

    assign done       = done_q;
    assign insn_count = cnt_q;

endmodule

// File: rtl/sbn_core_checker.sv
// Module: sbn_core_checker
// Port-level temporal checks for sbn_core, attached by bind below.
module sbn_core_checker #(
    parameter int XLEN = 32,
    parameter int RAW  = 5,
    parameter int CNTW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            soft_rst,
    input logic            done,
    input logic [CNTW-1:0] insn_count,
    input logic [RAW-1:0]  dbg_addr,
    input logic            dbg_we,
    input logic [XLEN-1:0] dbg_wdata,
    input logic [XLEN-1:0] dbg_rdata
);

    logic running;
    assign running = run_en & ~soft_rst & ~done;

    a_r1_r0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == '0) |-> (dbg_rdata == '0));

    a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (insn_count == $past(insn_count) + CNTW'(1)));

    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !soft_rst) |=> done);

    a_r5_halted_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !soft_rst) |=> $stable(insn_count));

    a_r6_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (insn_count == '0) && !done);

    a_r8_dbg_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && dbg_we && dbg_addr != '0) |=>
            ((dbg_addr != $past(dbg_addr)) || (dbg_rdata == $past(dbg_wdata))));

    a_r10_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !soft_rst) |=> ($stable(insn_count) && $stable(done)));

endmodule

bind sbn_core sbn_core_checker #(
    .XLEN (XLEN),
    .RAW  (RAW),
    .CNTW (CNTW)
) u_chk (.*);

// File: tb/test_sbn_core.sv
`timescale 1ns/1ps
// Bench: directed programs plus seeded random programs with colliding
// write traffic, compared against a behavioural model.
module test_sbn_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        soft_rst = 1'b0;
    logic        done;
    logic [31:0] insn_count;
    logic        imem_we = 1'b0;
    logic [3:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic [4:0]  dbg_addr = '0;
    logic        dbg_we = 1'b0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    logic [31:0] m_rf [32];
    logic [31:0] m_im [16];
    int          m_pc;
    bit          m_done;
    int unsigned m_cnt;

    sbn_core i_sbn_core (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [3:0] off, input bit mi, input bit si,
                                        input logic [7:0] dst, input logic [7:0] mn, input logic [7:0] sb);
        return {off, 2'b00, mi, si, dst, mn, sb};
    endfunction

    function automatic logic [31:0] sx8(input logic [7:0] f);
        return {{24{f[7]}}, f};
    endfunction

    // One model step from the requirements (R2, R3, R5).
    function automatic void m_step();
        logic [31:0] w, mv, sv, d;
        logic signed [3:0] o;
        int np;
        if (m_done) return;
        w  = m_im[m_pc];
        mv = w[25] ? sx8(w[15:8]) : m_rf[w[12:8]];
        sv = w[24] ? sx8(w[7:0])  : m_rf[w[4:0]];
        d  = mv - sv;
        if (w[20:16] != 0) m_rf[w[20:16]] = d;
        o  = w[31:28];
        np = d[31] ? (m_pc + int'(o)) : (m_pc + 1);
        m_cnt++;
        if (np < 0 || np > 15) m_done = 1'b1;
        else m_pc = np;
    endfunction

    task automatic dbg_write(input int r, input logic [31:0] v);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = 5'(r); dbg_wdata = v;
        @(negedge clk);
        dbg_we = 1'b0;
        if (r != 0) m_rf[r] = v;
    endtask

    task automatic imem_write(input int a, input logic [31:0] v);
        @(negedge clk);
        imem_we = 1'b1; imem_waddr = 4'(a); imem_wdata = v;
        @(negedge clk);
        imem_we = 1'b0;
        m_im[a] = v;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        m_pc = 0; m_done = 1'b0; m_cnt = 0;
    endtask

    // Run for k clocks; with noise, collide random writes with execution (R8, R9).
    task automatic run(input int k, input bit noise);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            run_en = 1'b1;
            if (noise && !m_done) begin
                dbg_we     = 1'($urandom);
                dbg_addr   = 5'($urandom);
                dbg_wdata  = $urandom;
                imem_we    = 1'($urandom);
                imem_waddr = 4'($urandom);
                imem_wdata = $urandom;
            end else begin
                dbg_we = 1'b0; imem_we = 1'b0;
            end
            m_step();
        end
        @(negedge clk);
        run_en = 1'b0; dbg_we = 1'b0; imem_we = 1'b0;
    endtask

    // Compare count, done and every register with the model.
    task automatic check_all(input string tag);
        chk(insn_count == m_cnt, {tag, " R4 count"}, insn_count, m_cnt);
        chk(done == m_done, {tag, " R5 done"}, 32'(done), 32'(m_done));
        for (int r = 0; r < 32; r++) begin
            dbg_addr = 5'(r);
            #0.1;
            chk(dbg_rdata == m_rf[r], {tag, " R2 reg"}, dbg_rdata, m_rf[r]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < 16; i++) m_im[i] = '0;
        m_pc = 0; m_done = 1'b0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6, R7: reset state visible through the debug port.
        chk(insn_count == 0, "R6 reset count", insn_count, 0);
        chk(done == 1'b0, "R6 reset done", 32'(done), 0);
        check_all("R7 reset");

        // R1: debug write to register 0 is discarded.
        dbg_write(0, 32'hDEAD_BEEF);
        dbg_addr = 5'd0; #0.1;
        chk(dbg_rdata == 0, "R1 r0 after write", dbg_rdata, 0);
        // R8: debug write while halted lands.
        dbg_write(9, 32'h0000_1234);
        dbg_addr = 5'd9; #0.1;
        chk(dbg_rdata == 32'h1234, "R8 halted write", dbg_rdata, 32'h1234);

        // Directed program A: constants, R0 destination, exit at PC 16 (R1, R3, R5).
        for (int i = 0; i < 16; i++) imem_write(i, '0);
        imem_write(0,  enc(4'd7, 1, 1, 8'd0,   8'd0,   8'd1));
        imem_write(7,  enc(4'd7, 1, 1, 8'hE3,  8'h80,  8'h7F));
        imem_write(14, enc(4'd3, 1, 1, 8'd4,   8'd1,   8'd0));
        imem_write(15, enc(4'd1, 1, 1, 8'd5,   8'd0,   8'd1));
        pulse_soft();
        run(20, 0);
        chk(insn_count == 4, "R3 path length A", insn_count, 4);
        chk(done == 1'b1, "R5 exit at 16", 32'(done), 1);
        dbg_addr = 5'd3; #0.1;
        chk(dbg_rdata == 32'hFFFF_FF01, "R2 imm -128 minus 127", dbg_rdata, 32'hFFFF_FF01);
        dbg_addr = 5'd0; #0.1;
        chk(dbg_rdata == 0, "R1 r0 after exec write", dbg_rdata, 0);
        check_all("A");

        // Directed program B: register operands, high field bits, exit below 0.
        dbg_write(10, 32'd100);
        dbg_write(11, 32'd30);
        imem_write(0, enc(4'd0, 0, 0, 8'd12, 8'hEA, 8'd11));
        imem_write(1, enc(4'h8, 0, 1, 8'd13, 8'd11, 8'd31));
        pulse_soft();
        chk(insn_count == 0 && done == 1'b0, "R6 soft clear", insn_count, 0);
        run(2, 0);
        chk(done == 1'b1, "R5 exit below 0", 32'(done), 1);
        dbg_addr = 5'd12; #0.1;
        chk(dbg_rdata == 32'd70, "R2 reg minus reg", dbg_rdata, 70);
        dbg_addr = 5'd13; #0.1;
        chk(dbg_rdata == 32'hFFFF_FFFF, "R2 reg minus imm", dbg_rdata, 32'hFFFF_FFFF);
        run(3, 0);
        chk(insn_count == 2, "R5 no exec after done", insn_count, 2);
        check_all("B");

        // Random programs with paused runs and colliding writes (R8, R9, R10).
        for (int p = 0; p < 30; p++) begin
            pulse_soft();
            check_all("R6 soft keeps regs");
            for (int j = 0; j < 4; j++) dbg_write(1 + ($urandom % 31), $urandom);
            for (int i = 0; i < 16; i++) imem_write(i, $urandom & 32'hF3FF_FFFF | ($urandom & 32'h0300_0000));
            run(1 + ($urandom % 25), 1);
            check_all("R8 R9 first leg");
            repeat ($urandom % 3) @(negedge clk);
            check_all("R10 paused");
            run(1 + ($urandom % 25), 1);
            check_all("R10 resumed");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule